// File: doc/BRIEF.md
# Lane Synchronous Scrambler

This block whitens one 64-bit lane word per clock. It XORs each word with a keystream taken from a free-running linear feedback generator with characteristic polynomial x^58 + x^38 + 1. The generator never looks at the data, so a bit error on the line stays a single bit error after descrambling. The generator moves forward on every clock, whether or not a word is present. Two words with the same content therefore scramble differently if they arrive on different cycles.

The same module runs on both ends of a lane. On the transmit side it scrambles. On the receive side it applies the identical XOR to recover the data. The receive side can also re-seed its generator from a received state-carrying control word, which brings it into step with the far end.

Each lane starts from its own seed. The seed is derived from a lane number pin, so that neighbouring lanes do not carry identical bit patterns after reset.

The stream interface carries a valid strobe and has no back-pressure. The keystream is tied to clock cycles rather than to accepted words, so a stall would break alignment with the far end. The consumer must therefore take every word in the cycle it is presented.

Top module: `lane_scrambler`

## Requirements
- R1: The keystream bits k[n] obey k[n] = k[n-20] XOR k[n-58]. Each clock consumes 64 consecutive keystream bits, and the oldest of them is applied to data bit 0.
- R2: The generator state holds the 58 most recent keystream bits, with bit i equal to k[n-1-i]. After `rst_n` is released, the first clock takes its state from the seed instead of the register. In the seed, bits 3:0 equal `lane_id` and bits 57:4 are ones.
- R3: A valid word with `in_ctrl`=0 (a data word) leaves the block as `in_data` XOR the 64 keystream bits of that clock.
- R4: A control word (`in_ctrl`=1) whose block type is 6'h1E (sync) or 6'h0A (state-carrying) is forwarded unchanged. Every other control word is scrambled like data. This includes 6'h07 (skip), 6'h19 (diagnostic) and any undefined code.
- R5: The generator advances by 64 bits on every clock after reset. This includes cycles with `in_valid`=0 and cycles that carry a bypassed word.
- R6: When `rx_mode`=1, a valid control word of type 6'h0A loads bits 57:0 of `in_data` into the generator state, in the bit order of R2. The word itself is forwarded unchanged, and the following clock uses the loaded state.
- R7: When `rx_mode`=0, a state-carrying word causes no load, and the generator continues its own sequence.
- R8: `out_valid` and `out_ctrl` follow `in_valid` and `in_ctrl` with one clock of latency. While `rst_n` is low, `out_valid`, `out_ctrl` and `out_data` are 0.
- R9: A state-carrying word presented with `in_valid`=0 causes no load, even when `rx_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_id | input | 4 | Lane number used to form the reset seed |
| rx_mode | input | 1 | 1 enables loading the state from received state-carrying words |
| in_valid | input | 1 | Input word strobe |
| in_ctrl | input | 1 | 1 marks a control word, 0 marks a data word |
| in_btype | input | 6 | Block type of a control word |
| in_data | input | 64 | Input word |
| out_valid | output | 1 | Output word strobe |
| out_ctrl | output | 1 | Control/data flag of the output word |
| out_data | output | 64 | Scrambled, descrambled or bypassed word |

## Verification
The assertions assume that `in_ctrl`, `in_btype` and `in_data` are only meaningful in cycles where `in_valid` is high. They also assume that `rx_mode` and `lane_id` are held steady across the stretch of traffic under check.

The bench changes `rx_mode` and `lane_id` only at phase boundaries, either while reset is applied or on idle cycles. It drives every input half a period away from the sampling edge.

Gaps of invalid cycles are mixed into the traffic so that the free-running advance is exercised. A state-carrying word is also presented with `in_valid` low, which checks that a load happens only on valid words.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int DATA_W = 64;
  localparam int ST_W   = 58;
  localparam int TAP    = 20;
  localparam int BT_W   = 6;

  typedef logic [BT_W-1:0] btype_t;

  localparam btype_t BT_SYNC  = 6'h1E;
  localparam btype_t BT_STATE = 6'h0A;
  localparam btype_t BT_SKIP  = 6'h07;
  localparam btype_t BT_DIAG  = 6'h19;
endpackage

// File: rtl/lsc_keygen.sv
module lsc_keygen #(
  parameter int DATA_W = 64,
  parameter int ST_W   = 58,
  parameter int TAP    = 20
) (
  input  logic [ST_W-1:0]   state_i,
  output logic [DATA_W-1:0] key_o,
  output logic [ST_W-1:0]   next_o
);
  // state bit i holds k[n-1-i]; each step yields k[n] = k[n-TAP] ^ k[n-ST_W]
  logic [ST_W-1:0] walk;
  logic            fb;

  always_comb begin
    walk  = state_i;
    fb    = 1'b0;
    key_o = '0;
    for (int j = 0; j < DATA_W; j++) begin
      fb       = walk[TAP-1] ^ walk[ST_W-1];
      key_o[j] = fb;
      walk     = {walk[ST_W-2:0], fb};
    end
    next_o = walk;
  end
endmodule

// File: rtl/lsc_classify.sv
module lsc_classify
  import lsc_pkg::*;
(
  input  logic   valid_i,
  input  logic   ctrl_i,
  input  btype_t btype_i,
  input  logic   rx_mode_i,
  output logic   bypass_o,
  output logic   load_o
);
  logic is_sync;
  logic is_state;

  assign is_sync  = (btype_i == BT_SYNC);
  assign is_state = (btype_i == BT_STATE);
  assign bypass_o = ctrl_i & (is_sync | is_state);
  assign load_o   = rx_mode_i & valid_i & ctrl_i & is_state;
endmodule

// File: rtl/lsc_state.sv
module lsc_state #(
  parameter int ST_W   = 58,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              load_i,
  input  logic [ST_W-1:0]   load_val_i,
  input  logic [ST_W-1:0]   next_i,
  output logic [ST_W-1:0]   cur_o
);
  logic [ST_W-1:0] seed;
  logic [ST_W-1:0] st_q;
  logic            fresh_q;

  for (genvar i = 0; i < ST_W; i++) begin : g_seed
    if (i < LANE_W) begin : g_lane
      assign seed[i] = lane_i[i];
    end else begin : g_one
      assign seed[i] = 1'b1;
    end
  end

  assign cur_o = fresh_q ? seed : st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      st_q    <= '1;
    end else begin
      fresh_q <= 1'b0;
      st_q    <= load_i ? load_val_i : next_i;
    end
  end
endmodule

// File: rtl/lane_scrambler.sv
module lane_scrambler
  import lsc_pkg::*;
#(
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_id,
  input  logic              rx_mode,
  input  logic              in_valid,
  input  logic              in_ctrl,
  input  logic [BT_W-1:0]   in_btype,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_ctrl,
  output logic [DATA_W-1:0] out_data
);
  logic [ST_W-1:0]   key_state;
  logic [ST_W-1:0]   next_state;
  logic [DATA_W-1:0] key;
  logic              bypass;
  logic              load;

  lsc_classify u_cls (
    .valid_i   (in_valid),
    .ctrl_i    (in_ctrl),
    .btype_i   (in_btype),
    .rx_mode_i (rx_mode),
    .bypass_o  (bypass),
    .load_o    (load)
  );

  lsc_state #(.ST_W(ST_W), .LANE_W(LANE_W)) u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_i     (lane_id),
    .load_i     (load),
    .load_val_i (in_data[ST_W-1:0]),
    .next_i     (next_state),
    .cur_o      (key_state)
  );

  lsc_keygen #(.DATA_W(DATA_W), .ST_W(ST_W), .TAP(TAP)) u_key (
    .state_i (key_state),
    .key_o   (key),
    .next_o  (next_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ctrl  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_ctrl  <= in_ctrl;
      out_data  <= bypass ? in_data : (in_data ^ key);
    end
  end
endmodule

// File: rtl/lane_scrambler_chk.sv
module lane_scrambler_chk
  import lsc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_mode,
  input logic              in_valid,
  input logic              in_ctrl,
  input logic [BT_W-1:0]   in_btype,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ctrl,
  input logic [DATA_W-1:0] out_data,
  input logic [ST_W-1:0]   key_state
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  // R8
  ctrl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_valid) |-> (out_ctrl == $past(in_ctrl)));

  // R4
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid && in_ctrl &&
                    (in_btype == BT_SYNC || in_btype == BT_STATE)))
    |-> (out_data == $past(in_data)));

  // R6
  state_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rx_mode && in_valid && in_ctrl && in_btype == BT_STATE))
    |-> (key_state == $past(in_data[ST_W-1:0])));
endmodule

bind lane_scrambler lane_scrambler_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_mode   (rx_mode),
  .in_valid  (in_valid),
  .in_ctrl   (in_ctrl),
  .in_btype  (in_btype),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ctrl  (out_ctrl),
  .out_data  (out_data),
  .key_state (key_state)
);

// File: tb/lane_scrambler_tb.sv
module lane_scrambler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lane_id = 4'd5;
  logic        rx_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ctrl = 1'b0;
  logic [5:0]  in_btype = 6'h00;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ctrl;
  logic [63:0] out_data;

  int    checks = 0;
  int    bad = 0;
  int    cycles = 0;
  string tag = "R8";

  always #4 clk = ~clk;

  lane_scrambler u_dut (
    .clk(clk), .rst_n(rst_n), .lane_id(lane_id), .rx_mode(rx_mode),
    .in_valid(in_valid), .in_ctrl(in_ctrl), .in_btype(in_btype),
    .in_data(in_data), .out_valid(out_valid), .out_ctrl(out_ctrl),
    .out_data(out_data)
  );

  // behavioural reference: hq[i] = k[n-1-i]
  bit          hq[$];
  bit          m_fresh = 1'b1;
  logic        exp_valid = 1'b0;
  logic        exp_ctrl = 1'b0;
  logic [63:0] exp_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fresh   = 1'b1;
      exp_valid = 1'b0;
      exp_ctrl  = 1'b0;
      exp_data  = '0;
    end else begin
      logic [63:0] ks;
      bit          pass;
      if (m_fresh) begin
        hq.delete();
        for (int i = 0; i < 58; i++) hq.push_back(i < 4 ? lane_id[i] : 1'b1);
        m_fresh = 1'b0;
      end
      for (int j = 0; j < 64; j++) begin
        bit b;
        b = hq[19] ^ hq[57];
        ks[j] = b;
        hq.push_front(b);
        void'(hq.pop_back());
      end
      pass = in_ctrl && (in_btype == 6'h1E || in_btype == 6'h0A);
      exp_data  = pass ? in_data : (in_data ^ ks);
      exp_valid = in_valid;
      exp_ctrl  = in_ctrl;
      if (rx_mode && in_valid && in_ctrl && in_btype == 6'h0A)
        for (int i = 0; i < 58; i++) hq[i] = in_data[i];
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== exp_valid) begin
        bad++;
        $display("FAIL %s out_valid act=%b exp=%b", tag, out_valid, exp_valid);
      end
      if (exp_valid) begin
        checks++;
        if (out_data !== exp_data || out_ctrl !== exp_ctrl) begin
          bad++;
          $display("FAIL %s out word act=%b/%h exp=%b/%h", tag,
                   out_ctrl, out_data, exp_ctrl, exp_data);
        end
      end
    end
  end

  task automatic drive(input logic v, input logic c, input logic [5:0] bt,
                       input logic [63:0] d);
    @(negedge clk);
    in_valid = v; in_ctrl = c; in_btype = bt; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 6'h00, '0);
  endtask

  task automatic check_reset_outputs();
    checks++;
    if (out_valid !== 1'b0 || out_ctrl !== 1'b0 || out_data !== '0) begin
      bad++;
      $display("FAIL R8 reset outputs act=%b/%b/%h exp=0/0/0",
               out_valid, out_ctrl, out_data);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #20;
    // R8: outputs held at zero under reset
    check_reset_outputs();
    @(negedge clk); rst_n = 1'b1;

    // R1: zero data exposes the raw keystream from the lane 5 seed
    tag = "R1";
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 6'h00, '0);

    // R3: random data words
    tag = "R3";
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 6'h00, rnd64());

    // R5: gaps of invalid cycles still advance the generator
    tag = "R5";
    for (int i = 0; i < 12; i++) begin
      drive(1'b1, 1'b0, 6'h00, rnd64());
      idle(i % 3);
    end

    // R4: each control type in transmit mode
    tag = "R4";
    drive(1'b1, 1'b1, 6'h1E, rnd64());
    drive(1'b1, 1'b1, 6'h07, rnd64());
    drive(1'b1, 1'b1, 6'h19, rnd64());
    drive(1'b1, 1'b1, 6'h00, rnd64());
    drive(1'b1, 1'b1, 6'h3F, rnd64());
    drive(1'b1, 1'b0, 6'h1E, rnd64());

    // R7: a state word without rx_mode loads nothing
    tag = "R7";
    drive(1'b1, 1'b1, 6'h0A, 64'h0000_0000_0000_0000);
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 6'h00, '0);
    idle(1);

    // R6: receive mode loads from a state word
    tag = "R6";
    rx_mode = 1'b1;
    drive(1'b1, 1'b1, 6'h0A, 64'hFFC0_1234_5678_9ABC);
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 6'h00, '0);
    drive(1'b1, 1'b1, 6'h0A, rnd64());
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 6'h00, rnd64());

    // R9: a state word without valid must not load
    tag = "R9";
    drive(1'b0, 1'b1, 6'h0A, 64'h0000_0000_0000_0001);
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 6'h00, '0);
    idle(1);
    rx_mode = 1'b0;

    // R2: new lane seed after a second reset
    tag = "R2";
    @(negedge clk); rst_n = 1'b0; lane_id = 4'd9;
    @(negedge clk);
    check_reset_outputs();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 6'h00, '0);
    @(negedge clk); rst_n = 1'b0; lane_id = 4'd0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 6'h00, rnd64());

    // R8: valid and flag latency with mixed strobes
    tag = "R8";
    for (int i = 0; i < 16; i++)
      drive(i[0], i[1], (i[2] ? 6'h19 : 6'h1E), rnd64());
    idle(3);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=%0d cycles exp=completion", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule